// File: doc/BRIEF.md
# Serial EEPROM Slave Transaction Engine

This block holds the byte-level behaviour of a serial EEPROM on a two-wire bus. It sits behind a bus front end that already handles bit timing and address matching. The front end reports bus events as single-cycle strobes:

- a start with the write direction, together with the 7-bit device address it received;
- a start with the read direction;
- a stop;
- a byte received from the master;
- a request for a byte to send to the master.

The engine answers each byte event with an ACK or NACK and each byte request with a data byte. Responses come one cycle after the event.

The capacity in bytes is the only parameter. The following are derived from it at elaboration:

| Capacity | Page size | Address bytes | Device-select bits | High address bits |
|---|---|---|---|---|
| 128 or 256 bytes | 8 | one | 3 | 0 |
| 512 bytes | 16 | one | 2 | 1 |
| 1024 bytes | 16 | one | 1 | 2 |
| 2048 bytes | 16 | one | 0 | 3 |
| 4096 or 8192 bytes | 32 | two | 3 | 0 |
| 16384 or 32768 bytes | 64 | two | 2 | 0 |
| 65536 bytes | 128 | two | 2 | 0 |
| 131072 bytes | 256 | two | 1 | 1 |

- **High address bits** are the low bits of the device address that select part of the word address.
- **Device-select bits** are filled from a board strap and sit just above the high address bits.

A master writes by sending the word address and then data. Data bytes land in an internal byte array. A write rolls over inside its page. A read uses a repeated start after the word address, or a plain read start that continues from the current address. Reads walk on and roll over at the end of the array. A write-protect input keeps the array unchanged.

Top module: `eeprom_txn_engine`

## Requirements
- R1: `addrHit` is high exactly when `busAddr`, with its high-address bits ignored, equals 0x50 OR'd with the strapped select value (`devNum` masked to the select width) shifted left by the number of high-address bits.
- R2: A write start from idle takes the high-address bits of `busAddr` as the top of the word address. They sit above bit 7 for one-byte parts and above bit 15 for two-byte parts. The next one (or two, high byte first) received bytes supply the rest of the word address, and each is ACKed.
- R3: Each data byte after the word address is stored at the current address. Only the in-page offset then increments: it rolls over to the start of the same page, and the page bits never change.
- R4: After the word address, a read start (repeated start) enters sequential read. Each requested byte comes from the current address, which then increments modulo the capacity.
- R5: A read start from idle begins a current-address read. It returns bytes from the address left by the previous transfer and increments in the same way as R4.
- R6: While `wp` is high, data bytes are still ACKed and the address still advances, but the array keeps its old contents.
- R7: A stop returns the engine to idle from any state. A byte received in idle is NACKed (`ackOut`=0) and a byte requested in idle returns 0x00.
- R8: A byte received in idle, current-address read or sequential read is NACKed and forces idle. A byte requested in any address or write state returns 0x00 and forces idle.
- R9: A write start while not idle returns the engine to idle without loading an address.
- R10: Every byte event gives exactly one `ackValid` pulse and every byte request exactly one `txValid` pulse, both in the cycle after the event. `ackOut`=1 means ACK.
- R11: A written byte is in the array when its ACK appears, so a read that starts right after the stop returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| devNum | input | 3 | Board-strapped device number |
| wp | input | 1 | Write protect, high blocks array updates |
| busAddr | input | 7 | Device address seen by the front end |
| addrHit | output | 1 | busAddr selects this device |
| evStartWr | input | 1 | Start with write direction (uses busAddr) |
| evStartRd | input | 1 | Start with read direction |
| evStop | input | 1 | Stop condition |
| evByteIn | input | 1 | Byte received from master |
| rxData | input | 8 | Received byte, valid with evByteIn |
| evByteReq | input | 1 | Master wants a byte |
| ackValid | output | 1 | Response to a received byte is valid |
| ackOut | output | 1 | 1 = ACK, 0 = NACK |
| txValid | output | 1 | Byte for the master is valid |
| txData | output | 8 | Byte for the master |

## Verification
The hardest cases to reach are the two roll-over paths, which meet only at the array's top page.

A write starting near a page end must fold back into the same page. A read crossing the last address must reach address zero. Reaching the last address of a one-byte part requires the high-address bit carried in the device address.

The stimulus fills the top page and the bottom page of two capacities, one with one-byte addressing and one with two-byte addressing. It then reads across the array end with a repeated start. A follow-up read start from idle checks that the read pointer survives the stop.

// File: rtl/eeprom_txn_pkg.sv
package eeprom_txn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CUR,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA0,
    ST_RD_DATA,
    ST_WR_DATA
  } txnState_e;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadHi;   // start write: seed address with device-address high bits
    logic setHi;    // merge upper word-address byte
    logic setLo;    // merge lower word-address byte
    logic wrByte;   // store data byte, page-bounded increment
    logic rdByte;   // fetch data byte, full-array increment
    logic badByte;  // unexpected byte: NACK
    logic badReq;   // unexpected request: send zero
  } dpCtl_t;

  function automatic int cfgPage(int capBytes);
    case (capBytes)
      512, 1024, 2048: return 16;
      4096, 8192:      return 32;
      16384, 32768:    return 64;
      65536:           return 128;
      131072:          return 256;
      default:         return 8;
    endcase
  endfunction

  function automatic int cfgSel(int capBytes);
    case (capBytes)
      512:                        return 2;
      1024:                       return 1;
      2048:                       return 0;
      16384, 32768, 65536:        return 2;
      131072:                     return 1;
      default:                    return 3;
    endcase
  endfunction

  function automatic int cfgHi(int capBytes);
    case (capBytes)
      512:     return 1;
      1024:    return 2;
      2048:    return 3;
      131072:  return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit cfgTwoByte(int capBytes);
    return capBytes >= 4096;
  endfunction

endpackage

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl
  import eeprom_txn_pkg::*;
#(
  parameter bit TWO_BYTE = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   evStartWr,
  input  logic   evStartRd,
  input  logic   evStop,
  input  logic   evByteIn,
  input  logic   evByteReq,
  output dpCtl_t ctl
);

  txnState_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (evStop) begin
      nextState = ST_IDLE;
    end else if (evStartWr) begin
      if (state == ST_IDLE) begin
        ctl.loadHi = 1'b1;
        nextState  = TWO_BYTE ? ST_ADDR_HI : ST_ADDR_LO;
      end else begin
        nextState = ST_IDLE;
      end
    end else if (evStartRd) begin
      case (state)
        ST_IDLE:  nextState = ST_RD_CUR;
        ST_DATA0: nextState = ST_RD_DATA;
        default:  nextState = ST_IDLE;
      endcase
    end else if (evByteIn) begin
      case (state)
        ST_ADDR_HI: begin
          ctl.setHi = 1'b1;
          nextState = ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          ctl.setLo = 1'b1;
          nextState = ST_DATA0;
        end
        ST_DATA0, ST_WR_DATA: begin
          ctl.wrByte = 1'b1;
          nextState  = ST_WR_DATA;
        end
        default: begin
          ctl.badByte = 1'b1;
          nextState   = ST_IDLE;
        end
      endcase
    end else if (evByteReq) begin
      case (state)
        ST_RD_CUR, ST_RD_DATA: ctl.rdByte = 1'b1;
        default: begin
          ctl.badReq = 1'b1;
          nextState  = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    evStop |=> state == ST_IDLE); // R7

  AST_BUSY_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (evStartWr && !evStop && state != ST_IDLE) |=> state == ST_IDLE); // R9

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl)); // R10

endmodule

// File: rtl/eeprom_txn_dp.sv
module eeprom_txn_dp
  import eeprom_txn_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter int PAGE      = 8,
  parameter int HI_BITS   = 0,
  parameter bit TWO_BYTE  = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  dpCtl_t     ctl,
  input  logic       wp,
  input  logic [6:0] busAddr,
  input  logic [7:0] rxData,
  output logic       ackValid,
  output logic       ackOut,
  output logic       txValid,
  output logic [7:0] txData
);

  localparam int AW    = $clog2(CAP_BYTES);
  localparam int LOW_W = TWO_BYTE ? 16 : 8;
  localparam logic [6:0]    HI_MASK = 7'((1 << HI_BITS) - 1);
  localparam logic [AW-1:0] PMASK   = ~(AW'(PAGE - 1));

  logic [7:0]    mem [CAP_BYTES];
  logic [AW-1:0] curAddr;
  logic [AW-1:0] seedAddr, hiMerged, loMerged, pageNext, linNext;
  logic [6:0]    hiVal;

  always_comb begin
    hiVal    = busAddr & HI_MASK;
    seedAddr = AW'(32'(hiVal) << LOW_W);
    hiMerged = curAddr | AW'(32'(rxData) << 8);
    loMerged = curAddr | AW'(rxData);
    linNext  = curAddr + 1'b1;
    pageNext = (curAddr & PMASK) | (linNext & ~PMASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr <= '0;
    end else if (ctl.loadHi) begin
      curAddr <= seedAddr;
    end else if (ctl.setHi) begin
      curAddr <= hiMerged;
    end else if (ctl.setLo) begin
      curAddr <= loMerged;
    end else if (ctl.wrByte) begin
      curAddr <= pageNext;
    end else if (ctl.rdByte) begin
      curAddr <= linNext;
    end
  end

  // Array commit happens with the byte itself: nothing is held back for stop.
  always_ff @(posedge clk) begin
    if (ctl.wrByte && !wp) mem[curAddr] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackValid <= 1'b0;
      ackOut   <= 1'b0;
      txValid  <= 1'b0;
      txData   <= 8'h00;
    end else begin
      ackValid <= ctl.setHi | ctl.setLo | ctl.wrByte | ctl.badByte;
      ackOut   <= ctl.setHi | ctl.setLo | ctl.wrByte;
      txValid  <= ctl.rdByte | ctl.badReq;
      if (ctl.rdByte)      txData <= mem[curAddr];
      else if (ctl.badReq) txData <= 8'h00;
    end
  end

  AST_WR_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ctl.wrByte |=> (curAddr & PMASK) == ($past(curAddr) & PMASK)); // R3

  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.rdByte |=> curAddr == $past(curAddr) + 1'b1); // R4

  AST_BADREQ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl.badReq |=> (txValid && txData == 8'h00)); // R8

  AST_BADBYTE_NACK: assert property (@(posedge clk) disable iff (rst)
    ctl.badByte |=> (ackValid && !ackOut)); // R8

endmodule

// File: rtl/eeprom_txn_engine.sv
module eeprom_txn_engine
  import eeprom_txn_pkg::*;
#(
  parameter int CAP_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] devNum,
  input  logic       wp,
  input  logic [6:0] busAddr,
  output logic       addrHit,
  input  logic       evStartWr,
  input  logic       evStartRd,
  input  logic       evStop,
  input  logic       evByteIn,
  input  logic [7:0] rxData,
  input  logic       evByteReq,
  output logic       ackValid,
  output logic       ackOut,
  output logic       txValid,
  output logic [7:0] txData
);

  localparam int PAGE     = cfgPage(CAP_BYTES);
  localparam int SEL_BITS = cfgSel(CAP_BYTES);
  localparam int HI_BITS  = cfgHi(CAP_BYTES);
  localparam bit TWO_BYTE = cfgTwoByte(CAP_BYTES);
  localparam logic [6:0] BASE_ADDR = 7'h50;
  localparam logic [6:0] HI_MASK   = 7'((1 << HI_BITS) - 1);
  localparam logic [6:0] SEL_MASK  = 7'((1 << SEL_BITS) - 1);

  logic [6:0] ownAddr;
  dpCtl_t     ctl;

  always_comb begin
    ownAddr = BASE_ADDR | (({4'b0, devNum} & SEL_MASK) << HI_BITS);
    addrHit = ((busAddr ^ ownAddr) & ~HI_MASK) == 7'd0;
  end

  eeprom_txn_ctrl #(.TWO_BYTE(TWO_BYTE)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .evStartWr (evStartWr),
    .evStartRd (evStartRd),
    .evStop    (evStop),
    .evByteIn  (evByteIn),
    .evByteReq (evByteReq),
    .ctl       (ctl)
  );

  eeprom_txn_dp #(
    .CAP_BYTES (CAP_BYTES),
    .PAGE      (PAGE),
    .HI_BITS   (HI_BITS),
    .TWO_BYTE  (TWO_BYTE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .wp       (wp),
    .busAddr  (busAddr),
    .rxData   (rxData),
    .ackValid (ackValid),
    .ackOut   (ackOut),
    .txValid  (txValid),
    .txData   (txData)
  );

  AST_ACK_ONLY_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    ackValid |-> $past(evByteIn)); // R10

  AST_TX_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    txValid |-> $past(evByteReq)); // R10

endmodule

// File: tb/eeprom_txn_engine_bench.sv
module eeprom_txn_engine_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       sWr [2];
  logic       sRd [2];
  logic       sStop [2];
  logic       sByte [2];
  logic       sReq [2];
  logic       wpIn [2];
  logic [7:0] rx [2];
  logic [6:0] ba [2];
  logic       hit [2];
  logic       ackV [2];
  logic       ackO [2];
  logic       txV [2];
  logic [7:0] txD [2];

  // DUT 0: 512 bytes, one address byte, page 16, 1 high bit, devNum=5 -> 0x52/0x53
  eeprom_txn_engine #(.CAP_BYTES(512)) u_eeprom_txn_engine (
    .clk(clk), .rst(rst), .devNum(3'b101), .wp(wpIn[0]), .busAddr(ba[0]),
    .addrHit(hit[0]), .evStartWr(sWr[0]), .evStartRd(sRd[0]), .evStop(sStop[0]),
    .evByteIn(sByte[0]), .rxData(rx[0]), .evByteReq(sReq[0]),
    .ackValid(ackV[0]), .ackOut(ackO[0]), .txValid(txV[0]), .txData(txD[0]));

  // DUT 1: 4096 bytes, two address bytes, page 32, no high bits, devNum=6 -> 0x56
  eeprom_txn_engine #(.CAP_BYTES(4096)) u_eeprom_txn_engine_wide (
    .clk(clk), .rst(rst), .devNum(3'b110), .wp(wpIn[1]), .busAddr(ba[1]),
    .addrHit(hit[1]), .evStartWr(sWr[1]), .evStartRd(sRd[1]), .evStop(sStop[1]),
    .evByteIn(sByte[1]), .rxData(rx[1]), .evByteReq(sReq[1]),
    .ackValid(ackV[1]), .ackOut(ackO[1]), .txValid(txV[1]), .txData(txD[1]));

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  int         qD [$];
  bit         qTx [$];
  logic [7:0] qV [$];
  string      qR [$];

  logic [7:0] refMem [2][4096];
  int refAddr [2];
  int capOf [2] = '{512, 4096};
  int pageOf [2] = '{16, 32};

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic popCheck(int d, bit isTx, logic [7:0] act);
    if (qD.size() == 0) begin
      chk(1'b0, "R10 unexpected response", int'(act), -1);
    end else begin
      int ed = qD.pop_front();
      bit et = qTx.pop_front();
      logic [7:0] ev = qV.pop_front();
      string er = qR.pop_front();
      chk(ed == d && et == isTx && act === ev, er, int'(act), int'(ev));
    end
  endtask

  // Monitor: the scoreboard side, sampling away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < 2; d++) begin
        if (ackV[d]) popCheck(d, 1'b0, {7'd0, ackO[d]});
        if (txV[d])  popCheck(d, 1'b1, txD[d]);
      end
    end
  end

  task automatic push(int d, bit isTx, logic [7:0] v, string req);
    qD.push_back(d); qTx.push_back(isTx); qV.push_back(v); qR.push_back(req);
  endtask

  task automatic clearAll();
    for (int d = 0; d < 2; d++) begin
      sWr[d] = 0; sRd[d] = 0; sStop[d] = 0; sByte[d] = 0; sReq[d] = 0;
    end
  endtask

  // kind: 0 start-write, 1 start-read, 2 stop, 3 byte in, 4 byte request
  task automatic pulse(int d, int kind, logic [7:0] v);
    @(posedge clk); #1;
    case (kind)
      0: begin ba[d] = v[6:0]; sWr[d] = 1; end
      1: sRd[d] = 1;
      2: sStop[d] = 1;
      3: begin rx[d] = v; sByte[d] = 1; end
      default: sReq[d] = 1;
    endcase
    @(posedge clk); #1;
    clearAll();
  endtask

  task automatic sendB(int d, logic [7:0] v, bit ack, string req);
    push(d, 1'b0, {7'd0, ack}, req);
    pulse(d, 3, v);
  endtask

  task automatic reqB(int d, string req);
    push(d, 1'b1, refMem[d][refAddr[d]], req);
    refAddr[d] = (refAddr[d] + 1) % capOf[d];
    pulse(d, 4, 8'h00);
  endtask

  task automatic badReq(int d, string req);
    push(d, 1'b1, 8'h00, req);
    pulse(d, 4, 8'h00);
  endtask

  task automatic setAddr(int d, int a, string req);
    if (d == 0) begin
      pulse(0, 0, 8'h52 | 8'((a >> 8) & 1));
      sendB(0, 8'(a), 1'b1, req);
    end else begin
      pulse(1, 0, 8'h56);
      sendB(1, 8'(a >> 8), 1'b1, req);
      sendB(1, 8'(a), 1'b1, req);
    end
    refAddr[d] = a;
  endtask

  task automatic writeData(int d, int n, int seed, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = 8'(seed + i * 7);
      sendB(d, v, 1'b1, req);
      if (!wpIn[d]) refMem[d][refAddr[d]] = v;
      refAddr[d] = (refAddr[d] & ~(pageOf[d] - 1)) |
                   ((refAddr[d] + 1) & (pageOf[d] - 1));
    end
  endtask

  task automatic writeBurst(int d, int a, int n, int seed, string req);
    setAddr(d, a, "R2");
    writeData(d, n, seed, req);
    pulse(d, 2, 8'h00);
  endtask

  task automatic readBurst(int d, int a, int n, string req);
    setAddr(d, a, "R2");
    pulse(d, 1, 8'h00);
    for (int i = 0; i < n; i++) reqB(d, req);
    pulse(d, 2, 8'h00);
  endtask

  task automatic hitCheck(int d, logic [6:0] a, bit exp);
    ba[d] = a; #1;
    chk(hit[d] === exp, "R1 addrHit", int'(hit[d]), int'(exp));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    clearAll();
    for (int d = 0; d < 2; d++) begin
      wpIn[d] = 0; rx[d] = 0; ba[d] = 0; refAddr[d] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!ackV[0] && !txV[0] && !ackV[1] && !txV[1], "R10 reset outputs idle", 0, 0);

    // R1: device address decoding with high bits ignored
    hitCheck(0, 7'h52, 1'b1);
    hitCheck(0, 7'h53, 1'b1);
    hitCheck(0, 7'h50, 1'b0);
    hitCheck(0, 7'h56, 1'b0);
    hitCheck(1, 7'h56, 1'b1);
    hitCheck(1, 7'h57, 1'b0);

    // R7: requests and bytes in idle
    badReq(0, "R7 request in idle gives 0x00");
    sendB(1, 8'h11, 1'b0, "R7 byte in idle NACK");

    // R3 + R2: high-bit addressed write that rolls inside page 0x1F0
    writeBurst(0, 9'h1F5, 20, 8'h30, "R3 page write ACK");
    readBurst(0, 9'h1F0, 16, "R3 page wrap readback");

    // R4 on one-byte part: read across array end, then R5 current address
    writeBurst(0, 9'h000, 4, 8'h90, "R3 write bottom page");
    readBurst(0, 9'h1FC, 4, "R4 read wraps to zero");
    pulse(0, 1, 8'h00);
    reqB(0, "R5 current-address read");
    reqB(0, "R5 current-address read");
    pulse(0, 2, 8'h00);

    // R3/R4 on two-byte part
    writeBurst(1, 12'hFFE, 6, 8'h41, "R3 wide page write");
    writeBurst(1, 12'h000, 8, 8'h05, "R3 wide bottom write");
    readBurst(1, 12'hFFE, 4, "R4 wide read wraps");
    readBurst(1, 12'hFE0, 4, "R3 wide page wrap readback");

    // R6: write protect
    writeBurst(1, 12'h100, 4, 8'hA0, "R6 pre-fill");
    wpIn[1] = 1;
    writeBurst(1, 12'h100, 4, 8'h17, "R6 protected write still ACKed");
    wpIn[1] = 0;
    readBurst(1, 12'h100, 5, "R6 contents unchanged");

    // R8 + R11: request in write state, then byte NACKed in idle
    setAddr(1, 12'h200, "R2");
    writeData(1, 1, 8'h6C, "R11 data ACK");
    badReq(1, "R8 request in write state gives 0x00");
    sendB(1, 8'h22, 1'b0, "R8 byte after forced idle NACK");
    pulse(1, 2, 8'h00);
    readBurst(1, 12'h200, 1, "R11 committed byte reads back");

    // R8: byte during sequential read
    setAddr(0, 9'h1F0, "R2");
    pulse(0, 1, 8'h00);
    reqB(0, "R4 read before bad byte");
    sendB(0, 8'h33, 1'b0, "R8 byte in read state NACK");
    badReq(0, "R8 engine idle after bad byte");

    // R9: write start while busy
    setAddr(0, 9'h010, "R2");
    pulse(0, 0, 8'h52);
    sendB(0, 8'h44, 1'b0, "R9 busy write start forces idle");
    pulse(0, 2, 8'h00);

    // R7: stop in the middle of the word address
    pulse(1, 0, 8'h56);
    sendB(1, 8'h03, 1'b1, "R2 high address byte");
    pulse(1, 2, 8'h00);
    sendB(1, 8'h55, 1'b0, "R7 stop mid-address returns idle");
    badReq(1, "R7 request after stop");

    repeat (3) @(negedge clk);
    chk(qD.size() == 0, "R10 all responses seen", qD.size(), 0);
    finishRun();
  end

endmodule